// File: doc/BRIEF.md
# SAR Converter Conversion and Readout Scheduler

This block sits on the host side of a successive-approximation converter's serial port. A phase counter runs on the system clock and raises the convert-start line once per cycle period. After each conversion the block drops chip select, which moves the result into the converter's output shift register. It then clocks the word in MSB first with a divided serial clock and returns it on a parallel bus with a one-cycle valid strobe.

The read for a conversion can take one of three placements. The early placement starts when the result is ready and gives the shortest response time. The late placement starts just after the next conversion's aperture window, so it tolerates a slower serial clock. The spanning placement starts early and may pause across the protected windows before it finishes. Around every convert-start edge there are two protected windows: a quiet window before the edge and an aperture window after it. No interface line may move inside either window. If the frame cannot fit the chosen placement, or the chosen late read is illegal for the converter's clock-master output mode, the block skips the sample and raises a sticky flag.

Top module: `adc_read_sched`

## Requirements
- R1: `convst_o` rises once every `T_CYCLE` clocks and stays high for `CNV_HIGH` clocks. The first rise comes `T_CYCLE` clocks after reset is released. Below, "phase" means the number of clocks since the most recent rise, and it is 0 in the rise cycle.
- R2: With `zone_i` = 2'b00 (early), `cs_n_o` falls at phase `T_CONV` of the cycle in which conversion N started. The word that frame returns is the result of conversion N.
- R3: With `zone_i` = 2'b01 (late), `cs_n_o` falls at phase `T_APER+1` of the cycle after conversion N started. The word returned is the result of conversion N. No frame is started before two conversions have begun.
- R4: With `zone_i` = 2'b10 (spanning), the frame starts at phase `T_CONV` and may run on into the next cycle. It pauses through the protected windows and returns the result of the conversion that started in the frame's first cycle.
- R5: `cs_n_o`, `sclk_o` and `convst_o` never change in a cycle whose phase is 0 to `T_APER`, or `T_CYCLE-T_QUIET` to `T_CYCLE-1`. The one exception is the rise of `convst_o` at phase 0.
- R6: A frame has exactly `BITS` rising edges of `sclk_o`. Each half period lasts `div_i` clocks, and a value of 0 counts as 1. `sclk_o` is high only while `cs_n_o` is low. Bits are taken MSB first on each rising edge. The word appears on `data_o` together with a one-cycle `data_valid_o` in the cycle `cs_n_o` rises.
- R7: A frame needs `2*BITS*div+2` unblocked clocks. The early window offers `T_CYCLE-T_QUIET-T_CONV` clocks, the late window `T_CONV-T_APER-1`, and the spanning window the sum of both. If the frame does not fit, no frame is started and `overrun_o` is set.
- R8: If the late placement is chosen while `clk_master_i`=1 and `clk_echo_i`=0, no frame is started and `cfg_err_o` is set. In clock-master mode the early and spanning placements are not affected.
- R9: Reset drives `convst_o`=0, `cs_n_o`=1, `sclk_o`=0, `data_valid_o`=0, `overrun_o`=0 and `cfg_err_o`=0. Both flags then stay set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| zone_i | input | 2 | Placement: 00 early, 01 late, 10 spanning, 11 same as early; sampled at each convert start |
| div_i | input | DIVW | Serial clock half period in system clocks |
| clk_master_i | input | 1 | Converter is in clock-master output mode |
| clk_echo_i | input | 1 | External clock echo selected in clock-master mode |
| sdo_i | input | 1 | Serial data from the converter |
| convst_o | output | 1 | Convert-start line |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| data_o | output | BITS | Last received sample word |
| data_valid_o | output | 1 | One-cycle strobe for `data_o` |
| overrun_o | output | 1 | Sticky: a frame did not fit its window |
| cfg_err_o | output | 1 | Sticky: illegal late read in clock-master mode |

## Verification
The hardest case to reach is a spanning frame that has to stop with the serial clock frozen. It goes through the quiet window and the next aperture window and then resumes. It must finish just before the following result is ready. It also must not collide with the next frame's start slot. The stimulus gets there by choosing dividers whose frames are longer than either window alone. One of them misses the combined budget by a single clock. A behavioural converter model shifts out a seeded random sample sequence, and every toggle is timed against the convert-start edges.

// File: rtl/adc_sched_pkg.sv
`timescale 1ns/1ps
package adc_sched_pkg;

  typedef enum logic [1:0] {
    ZONE_EARLY = 2'b00,
    ZONE_LATE  = 2'b01,
    ZONE_SPAN  = 2'b10,
    ZONE_RSVD  = 2'b11
  } zone_e;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SHIFT = 2'd1,
    FR_CLOSE = 2'd2
  } frame_st_e;

  typedef struct packed {
    zone_e zone;
    logic  master;
    logic  echo;
  } sched_cfg_t;

endpackage

// File: rtl/adc_sched_timer.sv
`timescale 1ns/1ps
module adc_sched_timer #(
  parameter int T_CYCLE  = 200,
  parameter int T_QUIET  = 12,
  parameter int T_APER   = 6,
  parameter int CNV_HIGH = 10,
  parameter int PW       = $clog2(T_CYCLE)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] phase_o,
  output logic [PW-1:0] nxt_phase_o,
  output logic          blk_now_o,
  output logic          blk_next_o,
  output logic          wrap_next_o,
  output logic          convst_o
);
  localparam logic [PW-1:0] PH_LAST   = PW'(T_CYCLE - 1);
  localparam logic [PW-1:0] PH_APER   = PW'(T_APER);
  localparam logic [PW-1:0] PH_QSTART = PW'(T_CYCLE - T_QUIET);
  localparam logic [PW-1:0] PH_CNVLO  = PW'(CNV_HIGH);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] nxt;

  function automatic logic in_blackout(input logic [PW-1:0] p);
    return (p <= PH_APER) || (p >= PH_QSTART);
  endfunction

  always_comb begin
    nxt = (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= '0;
      convst_o <= 1'b0;
    end else begin
      phase_q <= nxt;
      if (nxt == '0)
        convst_o <= 1'b1;
      else if (nxt == PH_CNVLO)
        convst_o <= 1'b0;
    end
  end

  assign phase_o     = phase_q;
  assign nxt_phase_o = nxt;
  assign blk_now_o   = in_blackout(phase_q);
  assign blk_next_o  = in_blackout(nxt);
  assign wrap_next_o = (nxt == '0);

  // R1: convert start rises only when the phase restarts
  p_cnv_rise_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(convst_o) |-> (phase_o == '0));

  // R5: convert start does not move inside a protected window except its rise
  p_cnv_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (blk_now_o && phase_o != '0) |-> $stable(convst_o));

endmodule

// File: rtl/adc_sched_frame.sv
`timescale 1ns/1ps
module adc_sched_frame
  import adc_sched_pkg::*;
#(
  parameter int BITS = 18,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            launch_i,
  input  logic            hold_i,
  input  logic [DIVW-1:0] div_i,
  input  logic            sdo_i,
  output logic            cs_n_o,
  output logic            sclk_o,
  output logic [BITS-1:0] data_o,
  output logic            valid_o,
  output logic            busy_o
);
  localparam int EW = $clog2(2 * BITS + 1);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * BITS - 1);

  frame_st_e       st_q;
  logic [DIVW-1:0] hcnt_q;
  logic [EW-1:0]   edges_q;
  logic [BITS-1:0] shreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= FR_IDLE;
      cs_n_o  <= 1'b1;
      sclk_o  <= 1'b0;
      hcnt_q  <= '0;
      edges_q <= '0;
      shreg_q <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (st_q)
        FR_IDLE: begin
          if (launch_i) begin
            cs_n_o  <= 1'b0;
            hcnt_q  <= '0;
            edges_q <= '0;
            st_q    <= FR_SHIFT;
          end
        end
        FR_SHIFT: begin
          if (!hold_i) begin
            if (hcnt_q == div_i - 1'b1) begin
              hcnt_q <= '0;
              sclk_o <= ~sclk_o;
              if (!sclk_o)
                shreg_q <= {shreg_q[BITS-2:0], sdo_i};
              if (edges_q == LAST_EDGE)
                st_q <= FR_CLOSE;
              else
                edges_q <= edges_q + 1'b1;
            end else begin
              hcnt_q <= hcnt_q + 1'b1;
            end
          end
        end
        FR_CLOSE: begin
          if (!hold_i) begin
            cs_n_o  <= 1'b1;
            data_o  <= shreg_q;
            valid_o <= 1'b1;
            st_q    <= FR_IDLE;
          end
        end
        default: st_q <= FR_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != FR_IDLE);

  // R5: a hold request from the timer freezes both framed lines
  p_hold_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> ($stable(cs_n_o) && $stable(sclk_o)));

  // R6: serial clock only pulses inside a selected frame
  p_sclk_framed_r6: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> !cs_n_o);

  // R6: result strobe lasts a single cycle
  p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

endmodule

// File: rtl/adc_read_sched.sv
`timescale 1ns/1ps
module adc_read_sched
  import adc_sched_pkg::*;
#(
  parameter int T_CYCLE  = 200,
  parameter int T_CONV   = 110,
  parameter int T_QUIET  = 12,
  parameter int T_APER   = 6,
  parameter int CNV_HIGH = 10,
  parameter int BITS     = 18,
  parameter int DIVW     = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      zone_i,
  input  logic [DIVW-1:0] div_i,
  input  logic            clk_master_i,
  input  logic            clk_echo_i,
  input  logic            sdo_i,
  output logic            convst_o,
  output logic            cs_n_o,
  output logic            sclk_o,
  output logic [BITS-1:0] data_o,
  output logic            data_valid_o,
  output logic            overrun_o,
  output logic            cfg_err_o
);
  localparam int PW = $clog2(T_CYCLE);
  localparam int NW = 24;
  localparam int W_EARLY = T_CYCLE - T_QUIET - T_CONV;
  localparam int W_LATE  = T_CONV - T_APER - 1;
  localparam logic [PW-1:0] PH_Z1 = PW'(T_CONV);
  localparam logic [PW-1:0] PH_Z2 = PW'(T_APER + 1);

  logic [PW-1:0]   phase, nxt_phase;
  logic            blk_now, blk_next, wrap_next;
  sched_cfg_t      cfg_q;
  logic [DIVW-1:0] div_q, eff_div;
  logic [1:0]      seen_q;
  logic [NW-1:0]   need, avail;
  logic            want_early, want_late, bad_cfg, no_fit, launch, busy;

  adc_sched_timer #(
    .T_CYCLE (T_CYCLE),
    .T_QUIET (T_QUIET),
    .T_APER  (T_APER),
    .CNV_HIGH(CNV_HIGH),
    .PW      (PW)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .phase_o    (phase),
    .nxt_phase_o(nxt_phase),
    .blk_now_o  (blk_now),
    .blk_next_o (blk_next),
    .wrap_next_o(wrap_next),
    .convst_o   (convst_o)
  );

  // settings and conversion count, refreshed at each convert start
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '{zone: ZONE_EARLY, master: 1'b0, echo: 1'b0};
      div_q  <= DIVW'(1);
      seen_q <= '0;
    end else if (wrap_next) begin
      cfg_q  <= '{zone: zone_e'(zone_i), master: clk_master_i, echo: clk_echo_i};
      div_q  <= div_i;
      if (seen_q != 2'd2)
        seen_q <= seen_q + 1'b1;
    end
  end

  always_comb begin
    eff_div    = (div_q == '0) ? DIVW'(1) : div_q;
    need       = NW'(2 * BITS) * NW'(eff_div) + NW'(2);
    case (cfg_q.zone)
      ZONE_LATE: avail = NW'(W_LATE);
      ZONE_SPAN: avail = NW'(W_EARLY + W_LATE);
      default:   avail = NW'(W_EARLY);
    endcase
    want_early = (nxt_phase == PH_Z1) && (cfg_q.zone != ZONE_LATE) && (seen_q != 2'd0);
    want_late  = (nxt_phase == PH_Z2) && (cfg_q.zone == ZONE_LATE) && (seen_q == 2'd2);
    bad_cfg    = want_late && cfg_q.master && !cfg_q.echo;
    no_fit     = need > avail;
    launch     = (want_early || want_late) && !bad_cfg && !no_fit && !busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      overrun_o <= 1'b0;
      cfg_err_o <= 1'b0;
    end else begin
      if ((want_early || want_late) && !bad_cfg && (no_fit || busy))
        overrun_o <= 1'b1;
      if (bad_cfg)
        cfg_err_o <= 1'b1;
    end
  end

  adc_sched_frame #(
    .BITS(BITS),
    .DIVW(DIVW)
  ) u_frame (
    .clk     (clk),
    .rst     (rst),
    .launch_i(launch),
    .hold_i  (blk_next),
    .div_i   (eff_div),
    .sdo_i   (sdo_i),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .data_o  (data_o),
    .valid_o (data_valid_o),
    .busy_o  (busy)
  );

  // R2: chip select falls only in one of the two start slots
  p_fall_slot_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> ((phase == PH_Z1) || (phase == PH_Z2)));

  // R3: a late frame needs a conversion from the previous cycle
  p_late_has_result_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n_o) && phase == PH_Z2) |-> (seen_q == 2'd2));

  // R5: framed lines hold still while the phase sits in a protected window
  p_lines_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    blk_now |-> ($stable(cs_n_o) && $stable(sclk_o)));

  // R9: overrun flag is sticky
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o);

  // R8: configuration error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |=> cfg_err_o);

endmodule

// File: tb/adc_read_sched_bench.sv
`timescale 1ns/1ps
module adc_read_sched_bench;
  localparam int T_CYCLE  = 200;
  localparam int T_CONV   = 110;
  localparam int T_QUIET  = 12;
  localparam int T_APER   = 6;
  localparam int CNV_HIGH = 10;
  localparam int BITS     = 18;
  localparam int DIVW     = 8;
  localparam int W_EARLY  = T_CYCLE - T_QUIET - T_CONV;
  localparam int W_LATE   = T_CONV - T_APER - 1;
  localparam int WD_CYC   = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] zone = 2'b00;
  logic [DIVW-1:0] div = DIVW'(1);
  logic master = 1'b0, echo = 1'b0, sdo = 1'b0;
  logic convst, cs_n, sclk, dvalid, ovr, cerr;
  logic [BITS-1:0] dout;

  always #5 clk = ~clk;

  adc_read_sched #(
    .T_CYCLE(T_CYCLE), .T_CONV(T_CONV), .T_QUIET(T_QUIET), .T_APER(T_APER),
    .CNV_HIGH(CNV_HIGH), .BITS(BITS), .DIVW(DIVW)
  ) u_adc_read_sched (
    .clk(clk), .rst(rst), .zone_i(zone), .div_i(div), .clk_master_i(master),
    .clk_echo_i(echo), .sdo_i(sdo), .convst_o(convst), .cs_n_o(cs_n),
    .sclk_o(sclk), .data_o(dout), .data_valid_o(dvalid), .overrun_o(ovr),
    .cfg_err_o(cerr)
  );

  int checks = 0, errors = 0;
  logic [BITS-1:0] smp [64];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [BITS-1:0] sample_of(input int n);
    return (n < 0) ? '0 : smp[n % 64];
  endfunction

  function automatic bit fits(input int z, input int dv);
    int eff, need, avail;
    eff   = (dv == 0) ? 1 : dv;
    need  = 2 * BITS * eff + 2;
    avail = (z == 2) ? W_EARLY + W_LATE : (z == 1) ? W_LATE : W_EARLY;
    return need <= avail;
  endfunction

  function automatic string ztag(input int z);
    return (z == 1) ? "R3" : (z == 2) ? "R4" : "R2";
  endfunction

  // behavioural converter and line monitor
  int rises, since, done_idx, m_zone, exp_per, seg_start;
  int per_valids, period_bad, valid_total;
  int blk_viol, period_viol, fall_err, fmt_err, frame_rises;
  logic cv_p, cs_p, sc_p;
  logic [BITS-1:0] sh, exp_word;
  bit ovr_m, err_m;

  always @(negedge clk) begin
    if (rst) begin
      rises = 0; since = 0; done_idx = -1; per_valids = 0;
      cv_p = 1'b0; cs_p = 1'b1; sc_p = 1'b0; sdo = 1'b0;
    end else begin
      if (convst && !cv_p) begin
        if (since != T_CYCLE - 1) period_viol++;
        if (rises - seg_start >= 4 && per_valids != exp_per) period_bad++;
        per_valids = 0;
        rises++;
        since = 0;
      end else begin
        since++;
        if (!convst && cv_p && since != CNV_HIGH) period_viol++;
      end
      if (since == T_CONV && rises > 0) done_idx = rises - 1;
      if ((cs_n != cs_p || sclk != sc_p) &&
          (since <= T_APER || since >= T_CYCLE - T_QUIET)) blk_viol++;
      if (!cs_n && cs_p) begin
        sh = sample_of(done_idx);
        sdo = sh[BITS-1];
        frame_rises = 0;
        exp_word = sample_of((m_zone == 1) ? rises - 2 : rises - 1);
        if (since != ((m_zone == 1) ? T_APER + 1 : T_CONV)) fall_err++;
      end
      if (sclk && !sc_p) frame_rises++;
      if (!sclk && sc_p && !cs_n) begin
        sh = {sh[BITS-2:0], 1'b0};
        sdo = sh[BITS-1];
      end
      if (cs_n && !cs_p && frame_rises != BITS) fmt_err++;
      if (dvalid) begin
        per_valids++;
        valid_total++;
        chk(dout == exp_word, ztag(m_zone), int'(dout), int'(exp_word));
      end
      cv_p = convst; cs_p = cs_n; sc_p = sclk;
    end
  end

  task automatic run_seg(input int z, input int dv, input bit ms, input bit ec,
                         input bit do_rst, input int nr);
    bit err_c, ft;
    int vbase, bbase;
    err_c = (z == 1) && ms && !ec;
    ft    = fits(z, dv);
    @(negedge clk); #1;
    zone = 2'(z); div = DIVW'(dv); master = ms; echo = ec; m_zone = z;
    if (do_rst) begin
      rst = 1'b1;
      repeat (3) @(negedge clk);
      #1 rst = 1'b0;
      ovr_m = 1'b0; err_m = 1'b0;
    end
    if (!err_c && !ft) ovr_m = 1'b1;
    if (err_c) err_m = 1'b1;
    exp_per   = (!err_c && ft) ? 1 : 0;
    seg_start = rises;
    vbase = valid_total; bbase = period_bad;
    while (rises < seg_start + nr) @(negedge clk);
    chk(period_bad == bbase, ztag(z), period_bad - bbase, 0);
    chk(ovr == ovr_m, "R7", int'(ovr), int'(ovr_m));
    chk(cerr == err_m, "R8", int'(cerr), int'(err_m));
    chk(blk_viol == 0, "R5", blk_viol, 0);
    chk(period_viol == 0, "R1", period_viol, 0);
    chk(fall_err == 0, ztag(z), fall_err, 0);
    chk(fmt_err == 0, "R6", fmt_err, 0);
    if (exp_per == 0) chk(valid_total == vbase, "R7 no frame", valid_total - vbase, 0);
    else chk(valid_total > vbase, ztag(z), valid_total - vbase, 1);
  endtask

  initial begin
    #(WD_CYC * 10);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) smp[i] = BITS'($urandom());
    m_zone = 0; exp_per = 0; seg_start = 0; valid_total = 0; period_bad = 0;
    blk_viol = 0; period_viol = 0; fall_err = 0; fmt_err = 0; frame_rises = 0;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(convst == 1'b0, "R9 convst", int'(convst), 0);
    chk(cs_n == 1'b1, "R9 cs_n", int'(cs_n), 1);
    chk(sclk == 1'b0, "R9 sclk", int'(sclk), 0);
    chk(dvalid == 1'b0, "R9 valid", int'(dvalid), 0);
    chk(ovr == 1'b0 && cerr == 1'b0, "R9 flags", int'({ovr, cerr}), 0);

    run_seg(0, 1, 0, 0, 1, 6);   // R2 fast clock
    run_seg(0, 2, 0, 0, 1, 6);   // R2 near full early window
    run_seg(1, 1, 0, 0, 1, 6);   // R3
    run_seg(1, 2, 0, 0, 1, 6);   // R3
    run_seg(2, 3, 0, 0, 1, 6);   // R4 pause across windows
    run_seg(2, 4, 0, 0, 1, 6);   // R4 longest fitting frame
    run_seg(0, 0, 0, 0, 1, 5);   // R6 divider 0 acts as 1
    run_seg(0, 3, 0, 0, 1, 4);   // R7 early does not fit
    run_seg(0, 1, 0, 0, 0, 6);   // R9 flag stays set, data flows
    run_seg(0, 1, 0, 0, 1, 5);   // R9 reset clears flag
    run_seg(1, 3, 0, 0, 1, 4);   // R7 late does not fit
    run_seg(2, 5, 0, 0, 1, 4);   // R7 spanning misses by one clock
    run_seg(1, 1, 1, 0, 1, 5);   // R8 illegal late read
    run_seg(1, 1, 1, 1, 1, 6);   // R8 echo makes late legal
    run_seg(0, 1, 1, 0, 1, 5);   // R8 early unaffected
    for (int k = 0; k < 5; k++) begin
      run_seg($urandom_range(0, 2), $urandom_range(0, 4),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1, 6);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule